// File: doc/BRIEF.md
# Trigger-Gated Sample Integrator with Timestamps

This block sums signed converter samples over the interval between two consecutive trigger events. It is meant for flux measurement, where a coil voltage is integrated between trigger pulses from an encoder or a timing system. Each recognized trigger closes the running integral and opens the next one in the same cycle. For every closed interval the block emits one record. The record holds the sum, the number of samples, the trigger timestamp, and two sub-sample residual times that a later interpolation stage uses to correct the interval edges.

A free-running time-base counter provides the timestamps. The same counter also produces the converter sample strobe through a divider with eight selectable ratios, so the residual times and the sampling instants share one time base. The trigger input is asynchronous and is synchronized inside the block. Records leave through a valid/ready handshake. A trigger that finds the previous record still unaccepted drops its record and raises a sticky overrun flag.

Top module: `trig_integrator`

## Requirements
- R1: The time-base counter is zero after reset and advances by one every clock. `trig_in` passes through two synchronizing registers. A rising edge is recognized in the cycle that follows the second clock edge at which `trig_in` is sampled high. `rec_ts` is the counter value in that cycle.
- R2: `sample_stb` is a one-cycle pulse every D clocks, where D = BASE_DIV * 2^`rate_sel` and `rate_sel` is 3 bits wide. The divider counts from 0 after reset and pulses when it holds D-1. If `rate_sel` changes so that the count already exceeds D-1, the divider wraps to 0 without a pulse.
- R3: While `en` is low, triggers are ignored and the block is disarmed. The first trigger recognized with `en` high only arms the block and produces no record. Every later trigger produces one.
- R4: `rec_sum` is the sign-extended sum of the `adc_data` values present in the strobe cycles of one interval. `rec_count` is the number of those strobe cycles. An interval runs from the cycle after the opening trigger up to and including the closing trigger cycle. A strobe that coincides with a trigger therefore belongs to the interval being closed.
- R5: `rec_tau_a` is the timestamp of the first sample of the interval minus the opening trigger timestamp. `rec_tau_b` is the closing trigger timestamp minus the timestamp of the last sample. `rec_tau_b` is 0 when a strobe and the trigger share a cycle. Both values are taken modulo 2^RES_W. In a record with a count of 0, both are 0.
- R6: Once `rec_valid` is raised, it and all record fields stay unchanged until a cycle with `rec_ready` high. After that cycle `rec_valid` is low, unless a new record was loaded in the same cycle.
- R7: A closing trigger that arrives while `rec_valid` is high and `rec_ready` is low drops its record and sets `overrun`. The accumulator still restarts at that trigger. `overrun` stays set until `en` is low.
- R8: During reset, `rec_valid`, `overrun`, `sample_stb` and all record fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Acquisition enable; low disarms and clears overrun |
| rate_sel | input | 3 | Sample divider select, D = BASE_DIV * 2^rate_sel |
| trig_in | input | 1 | Asynchronous trigger input |
| sample_stb | output | 1 | Converter sample strobe |
| adc_data | input | SAMPLE_W | Signed sample, taken in strobe cycles |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record accepted when high with rec_valid |
| rec_sum | output | SUM_W | Signed interval sum |
| rec_count | output | CNT_W | Samples in the interval |
| rec_ts | output | TS_W | Timestamp of the closing trigger |
| rec_tau_a | output | RES_W | Opening trigger to first sample, in ticks |
| rec_tau_b | output | RES_W | Last sample to closing trigger, in ticks |
| overrun | output | 1 | Sticky flag: a record was dropped |

## Verification
The bench aims triggers at every phase of the sample divider, including the cycle in which a strobe and a trigger coincide. A design that assigned that sample to the next interval would show a wrong count and sum in both neighbouring records, and a `rec_tau_b` that is not zero. The bench holds `rec_ready` low across several triggers. A design that overwrote the pending record, or that failed to restart the accumulator on a dropped trigger, would show changed fields while the record is held, or an inflated sum in the next record. It also toggles `en` to check that the arming trigger yields no record, and it switches the divider rate at run time so that a faulty wrap shows up as a misplaced strobe.

// File: rtl/ti_pkg.sv
package ti_pkg;

  // Divider ratio for a given rate select: base ticks doubled per step.
  function automatic int unsigned rate_divisor(input logic [2:0] sel,
                                               input int unsigned base);
    return base << sel;
  endfunction

endpackage

// File: rtl/ti_timebase.sv
module ti_timebase #(
  parameter int TS_W     = 32,
  parameter int BASE_DIV = 50,
  parameter int DIV_W    = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      rate_sel,
  output logic [TS_W-1:0] ts,
  output logic            stb
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_last;

  assign div_last = DIV_W'(ti_pkg::rate_divisor(rate_sel, BASE_DIV) - 32'd1);
  assign stb      = (div_cnt == div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts      <= '0;
      div_cnt <= '0;
    end else begin
      ts <= ts + 1'b1;
      if (div_cnt >= div_last) div_cnt <= '0;
      else                     div_cnt <= div_cnt + 1'b1;
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb); // R2

endmodule

// File: rtl/ti_trig_sync.sv
module ti_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic evt
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= trig_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign evt = sync_q & ~prev_q;

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R1

endmodule

// File: rtl/ti_accum.sv
module ti_accum #(
  parameter int SAMPLE_W = 18,
  parameter int SUM_W    = 48,
  parameter int CNT_W    = 24,
  parameter int TS_W     = 32,
  parameter int RES_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                stb,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                evt,
  input  logic [TS_W-1:0]     ts,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SUM_W-1:0]    out_sum,
  output logic [CNT_W-1:0]    out_cnt,
  output logic [TS_W-1:0]     out_ts,
  output logic [RES_W-1:0]    out_tau_a,
  output logic [RES_W-1:0]    out_tau_b,
  output logic                overrun
);
  localparam int EXT_W = SUM_W - SAMPLE_W;

  function automatic logic [SUM_W-1:0] widen(input logic [SAMPLE_W-1:0] s);
    return {{EXT_W{s[SAMPLE_W-1]}}, s};
  endfunction

  logic              armed;
  logic [SUM_W-1:0]  acc_sum;
  logic [CNT_W-1:0]  acc_cnt;
  logic [TS_W-1:0]   open_ts, first_ts, last_ts;

  logic [SUM_W-1:0]  cur_sum;
  logic [CNT_W-1:0]  cur_cnt;
  logic [TS_W-1:0]   first_c, last_c;
  logic [RES_W-1:0]  tau_a_c, tau_b_c;
  logic              close_evt, rec_load, rec_drop;

  always_comb begin
    cur_sum   = acc_sum + (stb ? widen(sample) : '0);
    cur_cnt   = acc_cnt + {{(CNT_W-1){1'b0}}, stb};
    first_c   = (stb && acc_cnt == '0) ? ts : first_ts;
    last_c    = stb ? ts : last_ts;
    tau_a_c   = (cur_cnt == '0) ? '0 : RES_W'(first_c - open_ts);
    tau_b_c   = (cur_cnt == '0) ? '0 : RES_W'(ts - last_c);
    close_evt = evt & armed & en;
    rec_load  = close_evt & (~out_valid | out_ready);
    rec_drop  = close_evt & out_valid & ~out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      acc_sum  <= '0;
      acc_cnt  <= '0;
      open_ts  <= '0;
      first_ts <= '0;
      last_ts  <= '0;
    end else if (!en) begin
      armed   <= 1'b0;
      acc_sum <= '0;
      acc_cnt <= '0;
    end else if (evt) begin
      armed   <= 1'b1;
      open_ts <= ts;
      acc_sum <= '0;
      acc_cnt <= '0;
    end else if (stb) begin
      acc_sum  <= cur_sum;
      acc_cnt  <= cur_cnt;
      first_ts <= first_c;
      last_ts  <= last_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_cnt   <= '0;
      out_ts    <= '0;
      out_tau_a <= '0;
      out_tau_b <= '0;
      overrun   <= 1'b0;
    end else begin
      if (rec_load) begin
        out_valid <= 1'b1;
        out_sum   <= cur_sum;
        out_cnt   <= cur_cnt;
        out_ts    <= ts;
        out_tau_a <= tau_a_c;
        out_tau_b <= tau_b_c;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (rec_drop)  overrun <= 1'b1;
      else if (!en)  overrun <= 1'b0;
    end
  end

  AST_HOLD_REC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum) &&
                                   $stable(out_cnt) && $stable(out_ts))); // R6
  AST_ARM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !armed && !out_valid) |=> !out_valid); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rec_drop |=> overrun); // R7
  AST_TAUB_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_load && stb) |=> (out_tau_b == '0)); // R5

endmodule

// File: rtl/trig_integrator.sv
module trig_integrator #(
  parameter int SAMPLE_W = 18,
  parameter int SUM_W    = 48,
  parameter int CNT_W    = 24,
  parameter int TS_W     = 32,
  parameter int RES_W    = 16,
  parameter int BASE_DIV = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [2:0]          rate_sel,
  input  logic                trig_in,
  output logic                sample_stb,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [SUM_W-1:0]    rec_sum,
  output logic [CNT_W-1:0]    rec_count,
  output logic [TS_W-1:0]     rec_ts,
  output logic [RES_W-1:0]    rec_tau_a,
  output logic [RES_W-1:0]    rec_tau_b,
  output logic                overrun
);
  localparam int DIV_W = $clog2(BASE_DIV * 128) + 1;

  logic [TS_W-1:0] ts_now;
  logic            trig_evt;

  ti_timebase #(.TS_W(TS_W), .BASE_DIV(BASE_DIV), .DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ts(ts_now), .stb(sample_stb)
  );

  ti_trig_sync u_sync (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .evt(trig_evt)
  );

  ti_accum #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .CNT_W(CNT_W),
             .TS_W(TS_W), .RES_W(RES_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .stb(sample_stb), .sample(adc_data),
    .evt(trig_evt), .ts(ts_now), .out_ready(rec_ready), .out_valid(rec_valid),
    .out_sum(rec_sum), .out_cnt(rec_count), .out_ts(rec_ts),
    .out_tau_a(rec_tau_a), .out_tau_b(rec_tau_b), .overrun(overrun)
  );

endmodule

// File: tb/trig_integrator_bench.sv
module trig_integrator_bench;
  localparam int SW = 18, SUMW = 48, CW = 24, TW = 32, RW = 16, BD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic trig_in = 1'b0;
  logic sample_stb;
  logic [SW-1:0] adc_data = '0;
  logic rec_valid;
  logic rec_ready = 1'b0;
  logic [SUMW-1:0] rec_sum;
  logic [CW-1:0] rec_count;
  logic [TW-1:0] rec_ts;
  logic [RW-1:0] rec_tau_a, rec_tau_b;
  logic overrun;

  always #4 clk = ~clk;

  trig_integrator #(.SAMPLE_W(SW), .SUM_W(SUMW), .CNT_W(CW), .TS_W(TW),
                    .RES_W(RW), .BASE_DIV(BD)) u_trig_integrator (
    .clk(clk), .rst_n(rst_n), .en(en), .rate_sel(rate_sel), .trig_in(trig_in),
    .sample_stb(sample_stb), .adc_data(adc_data), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_sum(rec_sum), .rec_count(rec_count),
    .rec_ts(rec_ts), .rec_tau_a(rec_tau_a), .rec_tau_b(rec_tau_b),
    .overrun(overrun)
  );

  int checks = 0, errors = 0;
  int n_rec = 0, n_zero_b = 0, n_ovr = 0;

  // reference state
  longint t_now = 0, div_pos = 0;
  bit h1 = 0, h2 = 0, h3 = 0;
  bit live = 0, v = 0, ov = 0;
  longint acc = 0, n_acc = 0, t_open = 0, t_first = 0, t_last = 0;
  longint e_sum = 0, e_cnt = 0, e_ts = 0, e_ta = 0, e_tb = 0;

  int hold = 0, gap = 5;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic predict();
    longint period = longint'(BD) * (longint'(1) << rate_sel);
    bit s = (div_pos == period - 1);
    bit tr = h2 && !h3;
    longint smp = longint'($signed(adc_data));
    longint nsum = acc + (s ? smp : 0);
    longint ncnt = n_acc + (s ? 1 : 0);
    longint f = (s && n_acc == 0) ? t_now : t_first;
    longint l = s ? t_now : t_last;
    bit closing = tr && live && en;
    if (v && rec_ready) begin
      n_rec++;
      if (e_tb == 0 && e_cnt != 0) n_zero_b++;
    end
    if (closing && v && !rec_ready) begin ov = 1; n_ovr++; end
    else if (!en) ov = 0;
    if (closing && (!v || rec_ready)) begin
      v = 1; e_sum = nsum; e_cnt = ncnt; e_ts = t_now;
      e_ta = (ncnt == 0) ? 0 : ((f - t_open) & 64'hFFFF);
      e_tb = (ncnt == 0) ? 0 : ((t_now - l) & 64'hFFFF);
    end else if (rec_ready) v = 0;
    if (!en) begin live = 0; acc = 0; n_acc = 0; end
    else if (tr) begin live = 1; t_open = t_now; acc = 0; n_acc = 0; end
    else if (s) begin acc = nsum; n_acc = ncnt; t_first = f; t_last = l; end
    div_pos = (div_pos >= period - 1) ? 0 : div_pos + 1;
    t_now = (t_now + 1) & 64'hFFFF_FFFF;
    h3 = h2; h2 = h1; h1 = trig_in;
  endtask

  task automatic compare();
    longint period = longint'(BD) * (longint'(1) << rate_sel);
    chk("R2 sample_stb", longint'(sample_stb), longint'(div_pos == period - 1));
    chk("R6 rec_valid", longint'(rec_valid), longint'(v));
    chk("R7 overrun", longint'(overrun), longint'(ov));
    if (v) begin
      chk("R4 rec_sum", longint'($signed(rec_sum)), e_sum);
      chk("R4 rec_count", longint'(rec_count), e_cnt);
      chk("R1 rec_ts", longint'(rec_ts), e_ts);
      chk("R5 rec_tau_a", longint'(rec_tau_a), e_ta);
      chk("R5 rec_tau_b", longint'(rec_tau_b), e_tb);
    end
  endtask

  task automatic cycle();
    predict();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  // ready_pct: 100 always ready, 0 never; dmode 1 gives full-scale data
  task automatic run(int n, int gmin, int gmax, int ready_pct, int dmode);
    for (int i = 0; i < n; i++) begin
      if (hold > 0) begin trig_in = 1'b1; hold--; end
      else if (gap > 0) begin trig_in = 1'b0; gap--; end
      else begin
        trig_in = 1'b1; hold = 2;
        gap = gmin + int'($urandom % (gmax - gmin + 1));
      end
      rec_ready = (int'($urandom % 100) < ready_pct);
      if (dmode == 1) adc_data = ($urandom % 2 == 0) ? 18'h1FFFF : 18'h20000;
      else adc_data = SW'($urandom);
      cycle();
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 reset rec_valid", longint'(rec_valid), 0);
      chk("R8 reset overrun", longint'(overrun), 0);
      chk("R8 reset sample_stb", longint'(sample_stb), 0);
      chk("R8 reset rec_sum", longint'(rec_sum), 0);
      chk("R8 reset rec_ts", longint'(rec_ts), 0);
    end
    rst_n = 1'b1;
    // disabled: triggers ignored (R3)
    run(150, 10, 20, 100, 0);
    chk("R3 no record while disabled", longint'(n_rec), 0);
    en = 1'b1;
    run(600, 15, 40, 100, 0);
    run(600, 15, 40, 50, 1);
    // stalled consumer forces drops (R7)
    run(300, 15, 30, 0, 0);
    run(100, 15, 30, 100, 0);
    en = 1'b0;
    run(200, 15, 30, 100, 0);
    en = 1'b1; rate_sel = 3'd2;
    run(1500, 40, 100, 60, 0);
    rate_sel = 3'd7;
    run(8000, 800, 1500, 80, 1);
    rate_sel = 3'd1;
    run(800, 12, 30, 100, 0);
    chk("R4 records delivered", longint'(n_rec > 20), 1);
    chk("R5 coincident strobe seen", longint'(n_zero_b > 0), 1);
    chk("R7 overrun exercised", longint'(n_ovr > 0), 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule